// File: doc/BRIEF.md
# Least-Recently-Used Packet Arbiter for One Switch Output

This block schedules a single output port of an input-buffered packet switch. Each input's routing stage raises a request line when its head packet wants this output. The arbiter grants exactly one input and keeps that grant for the whole packet, which cut-through forwarding needs. It releases the grant only when the tail flit of the packet is transferred. One instance sits on each output, so every output arbitrates independently. Input queues, the crossbar and link flow control are outside the block.

Fairness comes from a true least-recently-used order over the input indices. The arbiter picks the requesting input that sits closest to the least-recent end of this list. When that input's packet completes, it moves to the most-recent end, and all other inputs keep their relative positions. Within one input, packets are served strictly in arrival order, because the arbiter only ever sees each input's head packet.

Top module: `lru_pkt_arb`

## Requirements
- R1: After reset, `gnt_o` is zero and the order list ranks input 0 as least recent and input N-1 as most recent. With all inputs requesting one-flit packets back to back, grants therefore go to inputs 0, 1, ..., N-1 in that sequence.
- R2: `gnt_o` always has at most one bit set. Bit k set means input k owns the output.
- R3: When `gnt_o` is zero and `req_i` is zero at a clock edge, `gnt_o` stays zero after that edge.
- R4: When `gnt_o` is zero and `req_i` is non-zero at a clock edge, `gnt_o` after that edge selects the requesting input nearest the least-recent end of the order list.
- R5: While a grant is held, it does not change at any edge without a tail handshake. This holds whatever `req_i` does, and also on cycles with `xfer_i` low or with `xfer_i` high and `tail_i` low.
- R6: A tail handshake is `xfer_i` and `tail_i` both high while `gnt_o` is non-zero. At the edge where it happens, `gnt_o` returns to zero. A new grant can then be issued at the following edge.
- R7: At a tail handshake, the granted input moves to the most-recent end of the order list. The other inputs keep their relative order.
- R8: `xfer_i` and `tail_i` have no effect while `gnt_o` is zero. The order list and the grant stay unchanged.
- R9: The order list changes only at a tail handshake. Idle cycles and cycles inside a packet leave it untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_IN | Per-input request for this output |
| xfer_i | input | 1 | A flit of the granted packet moves through the output this cycle |
| tail_i | input | 1 | The flit moving this cycle is the packet's last |
| gnt_o | output | N_IN | Registered one-hot grant, zero when the output is free |

## Verification
The hardest state to reach from the ports is a scrambled order list in which the least-recent requester is far from its reset position. The only way to change the order is to complete packets, so each order state depends on the whole history of grants. The bench keeps its own model of the order and drives every one of the 256 request patterns three times over, with packet lengths that vary. This walks the list through many permutations. During each packet the request lines are switched to an unrelated pattern and a stalled tail-without-transfer cycle is inserted, to show that the held grant ignores both.

// File: rtl/lru_arb_pkg.sv
package lru_arb_pkg;
  parameter int unsigned NUM_IN_DEF = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_order_list.sv
module lru_order_list #(
  parameter int unsigned N_IN = lru_arb_pkg::NUM_IN_DEF,
  localparam int unsigned IW  = lru_arb_pkg::idx_w(N_IN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [IW-1:0]            win_idx_i,
  output logic [N_IN-1:0][IW-1:0]  order_o
);
  logic [N_IN-1:0][IW-1:0] order_q, order_d;
  logic [N_IN-1:0]         past_win;

  // entries from the winner's slot onward shift one step toward the LRU end
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (order_q[i] == win_idx_i) seen = 1'b1;
      past_win[i] = seen;
    end
    for (int i = 0; i < N_IN; i++) begin
      if (i == N_IN - 1)    order_d[i] = win_idx_i;
      else if (past_win[i]) order_d[i] = order_q[i+1];
      else                  order_d[i] = order_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_IN; i++) order_q[i] <= IW'(i);
    end else if (upd_i) begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

  // every input index appears exactly once in the list
  for (genvar v = 0; v < N_IN; v++) begin : g_perm
    logic [N_IN-1:0] hit;
    for (genvar s = 0; s < N_IN; s++) begin : g_slot
      assign hit[s] = (order_q[s] == IW'(v));
    end
    assert_order_perm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit) == 1);
  end

  assert_winner_to_mru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> order_q[N_IN-1] == $past(win_idx_i));

  assert_order_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(order_q));
endmodule

// File: rtl/lru_pick.sv
module lru_pick #(
  parameter int unsigned N_IN = lru_arb_pkg::NUM_IN_DEF,
  localparam int unsigned IW  = lru_arb_pkg::idx_w(N_IN)
) (
  input  logic [N_IN-1:0]          req_i,
  input  logic [N_IN-1:0][IW-1:0]  order_i,
  output logic                     hit_o,
  output logic [IW-1:0]            idx_o
);
  logic [N_IN-1:0] slot_req;

  for (genvar s = 0; s < N_IN; s++) begin : g_slot
    assign slot_req[s] = req_i[order_i[s]];
  end

  // first requesting slot from the LRU end wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int s = 0; s < N_IN; s++) begin
      if (slot_req[s] && !hit_o) begin
        hit_o = 1'b1;
        idx_o = order_i[s];
      end
    end
  end

  always_comb begin
    assert_pick_requester_R4: assert (!hit_o || req_i[idx_o]);
  end
endmodule

// File: rtl/lru_pkt_arb.sv
module lru_pkt_arb #(
  parameter int unsigned N_IN = lru_arb_pkg::NUM_IN_DEF,
  localparam int unsigned IW  = lru_arb_pkg::idx_w(N_IN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] req_i,
  input  logic            xfer_i,
  input  logic            tail_i,
  output logic [N_IN-1:0] gnt_o
);
  logic [N_IN-1:0]         gnt_q, gnt_d;
  logic [N_IN-1:0][IW-1:0] order;
  logic                    busy, tail_hs, pick_hit;
  logic [IW-1:0]           pick_idx, own_idx;

  assign busy    = |gnt_q;
  assign tail_hs = busy & xfer_i & tail_i;

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (gnt_q[i]) own_idx = own_idx | IW'(i);
    end
  end

  lru_order_list #(.N_IN(N_IN)) u_order (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (tail_hs),
    .win_idx_i (own_idx),
    .order_o   (order)
  );

  lru_pick #(.N_IN(N_IN)) u_pick (
    .req_i   (req_i),
    .order_i (order),
    .hit_o   (pick_hit),
    .idx_o   (pick_idx)
  );

  always_comb begin
    gnt_d = gnt_q;
    if (tail_hs) begin
      gnt_d = '0;
    end else if (!busy && pick_hit) begin
      gnt_d = '0;
      gnt_d[pick_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  assert_idle_stays_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i == '0) |=> gnt_q == '0);

  assert_grant_to_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i != '0) |=> (gnt_q & $past(req_i)) != '0);

  assert_grant_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tail_hs) |=> $stable(gnt_q));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_hs |=> gnt_q == '0);

  assert_no_effect_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && xfer_i && tail_i && req_i == '0) |=> gnt_q == '0);
endmodule

// File: tb/lru_pkt_arb_test.sv
module lru_pkt_arb_test;
  localparam int N = 8;
  localparam time CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         xfer = 1'b0;
  logic         tail = 1'b0;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;
  int ord [N];

  always #(CLK_P/2) clk = ~clk;

  lru_pkt_arb #(.N_IN(N)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .xfer_i (xfer),
    .tail_i (tail),
    .gnt_o  (gnt)
  );

  task automatic chk(input bit ok, input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: gnt actual %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int model_pick(input logic [N-1:0] r);
    for (int p = 0; p < N; p++) if (r[ord[p]]) return ord[p];
    return -1;
  endfunction

  task automatic model_to_mru(input int w);
    int p;
    p = 0;
    for (int i = 0; i < N; i++) if (ord[i] == w) p = i;
    for (int i = p; i < N - 1; i++) ord[i] = ord[i+1];
    ord[N-1] = w;
  endtask

  // one packet: request, grant edge, optional stall, flits with noisy requests
  task automatic pkt(input logic [N-1:0] r, input int len, input logic [N-1:0] noise,
                     output logic [N-1:0] seen);
    logic [N-1:0] exp;
    int w;
    req = r; xfer = 1'b0; tail = 1'b0;
    @(posedge clk); #1;
    seen = gnt;
    chk($countones(gnt) <= 1, "R2", gnt, gnt);
    if (r == '0) begin
      chk(gnt == '0, "R3", gnt, '0);
      return;
    end
    w = model_pick(r);
    exp = '0; exp[w] = 1'b1;
    chk(gnt == exp, "R4", gnt, exp);
    // tail asserted without transfer must not release
    req = noise; tail = 1'b1;
    @(posedge clk); #1;
    chk(gnt == exp, "R5", gnt, exp);
    for (int k = 0; k < len; k++) begin
      req = noise ^ N'(k); xfer = 1'b1; tail = (k == len - 1);
      @(posedge clk); #1;
      if (k < len - 1) chk(gnt == exp, "R5", gnt, exp);
      else             chk(gnt == '0, "R6", gnt, '0);
    end
    xfer = 1'b0; tail = 1'b0; req = '0;
    model_to_mru(w);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] seen;
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) ord[i] = i;
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == '0, "R1", gnt, '0);
    rst_n = 1'b1;

    // R1: reset order serves 0..N-1; R6: each grant issued one edge after release
    for (int i = 0; i < N; i++) begin
      pkt('1, 1, '1, seen);
      e = '0; e[i] = 1'b1;
      chk(seen == e, "R1", seen, e);
    end

    // sweep of all request patterns with varying lengths
    for (int rep = 0; rep < 3; rep++) begin
      for (int p = 0; p < (1 << N); p++) begin
        pkt(N'(p), (p + rep) % 4 + 1, ~N'(p) ^ N'(rep * 37), seen);
      end
    end

    // R8: transfer/tail with no grant
    req = '0; xfer = 1'b1; tail = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(gnt == '0, "R8", gnt, '0);
    end
    xfer = 1'b0; tail = 1'b0;
    e = '0; e[ord[0]] = 1'b1;
    pkt('1, 2, '0, seen);
    chk(seen == e, "R8", seen, e);

    // R9: idle cycles leave the order alone
    repeat (5) @(posedge clk);
    #1;
    e = '0; e[ord[0]] = 1'b1;
    pkt('1, 1, 8'h5a, seen);
    chk(seen == e, "R9", seen, e);

    // R7: full order read out through all-request packets
    for (int i = 0; i < N; i++) begin
      e = '0; e[ord[0]] = 1'b1;
      pkt('1, 1, '1, seen);
      chk(seen == e, "R7", seen, e);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule